// File: doc/BRIEF.md
# Byte-Stream Register Access Engine

This block sits between a byte-wide host link and an on-chip register bus. The host sends commands, each a single ASCII character byte, sometimes followed by raw binary argument bytes sent most significant byte first. The engine interprets them and produces register bus cycles, and it returns any read data to the host as a stream of bytes.

The engine holds a 32-bit address pointer and a 16-bit transfer count. The pointer can be loaded in full or in part, stepped up or down and read back. The count selects how many items the next transfer command moves, and it also sets whether the address advances after each item or stays fixed, which suits a FIFO behind a single register. An item is 1 to 4 bytes wide. When a block ends, the count returns to one and the pointer returns to the address where the block began, so that a later single access reaches the same register.

The bus carries the low 24 bits of the pointer. Bits 23:16 select a type of unit, bits 15:8 a unit number and bits 7:0 a register inside the unit. Data are right-aligned on the bus and the width is given as bytes minus one. Read data arrive the cycle after the read strobe, together with a hit flag. A miss returns bytes of 0xFF, so a host that scans register 0 of each unit can find the empty positions.

Top module: `byte_reg_engine`

## Requirements
- R1: Command 0x41 ('A') takes 4 argument bytes and loads pointer bits 31:0. Command 0x53 ('S') takes 3 bytes and loads bits 23:0. Command 0x61 ('a') takes 1 byte and loads bits 7:0. Arguments are sent most significant byte first, and the pointer bits that are not loaded keep their value.
- R2: Command 0x2B ('+') adds one to the pointer and 0x2D ('-') subtracts one, both modulo 2^32. Command 0x52 ('R') returns the 4 pointer bytes, most significant first.
- R3: A command byte that is not listed in R1, R2, R4, R5 or R7 is dropped with no bus cycle and no output, and the byte after it is decoded as a command.
- R4: Write commands 0x4C ('L'), 0x54 ('T'), 0x57 ('W') and 0x42 ('B') move items of 4, 3, 2 and 1 bytes. Each item's bytes arrive most significant first and produce one write strobe. On that strobe bus_wdata holds the item right-aligned with zero upper bytes, bus_width holds the byte count minus one, and bus_addr holds pointer bits 23:0, so pointer bits 31:24 never reach the bus.
- R5: Command 0x4E ('N') with 2 bytes loads the count and selects advancing mode, in which the pointer rises by one after each item. Command 0x46 ('F') with 2 bytes loads the count and selects fixed mode, in which every item uses the same address. A transfer command moves count items, and a count of 0 moves one item.
- R6: After each transfer command the count is 1 and the pointer equals its value when the command arrived.
- R7: Read commands 0x6C ('l'), 0x74 ('t'), 0x77 ('w') and 0x62 ('b') issue one single-cycle read strobe per item, at the address given by R4 and R5. The bus data the cycle after the strobe are returned as 4, 3, 2 or 1 bytes, most significant first, and an output byte is held until it is accepted.
- R8: When bus_hit is low in the cycle after a read strobe, every byte returned for that item is 0xFF.
- R9: A read strobe is not issued while output bytes of an earlier item are still waiting, and in_ready is low while any output byte is waiting.
- R10: After reset the pointer is 0, the count is 1, advancing mode is selected, no strobe or output byte is active and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Host byte present |
| in_data | input | 8 | Host byte |
| in_ready | output | 1 | Engine accepts the host byte this cycle |
| out_valid | output | 1 | Return byte present |
| out_data | output | 8 | Return byte |
| out_ready | input | 1 | Host accepts the return byte |
| bus_addr | output | 24 | Register bus address |
| bus_wdata | output | 32 | Write data, right-aligned |
| bus_width | output | 2 | Item byte count minus one |
| bus_wr | output | 1 | Single-cycle write strobe |
| bus_rd | output | 1 | Single-cycle read strobe |
| bus_rdata | input | 32 | Read data, valid the cycle after bus_rd |
| bus_hit | input | 1 | A unit answered the read, valid with bus_rdata |

## Verification
A corrupted pointer shows up at the next bus strobe as a wrong bus_addr, or at the next 'R' command as wrong returned bytes. A wrong count or mode shows up during the block that uses it, as a wrong number of strobes or as addresses that advance when they should stay fixed. A restore that fails stays hidden until the next transfer after the block, so every block test is followed by a pointer read and by a single transfer. Problems in flow control show up within a few cycles, either as a read strobe that overtakes waiting output bytes or as an output byte that changes while it is stalled.

// File: rtl/bre_pkg.sv
package bre_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARG, ST_RD, ST_STRB, ST_CAP
  } eng_state_t;

  typedef enum logic [1:0] {
    DST_PTR, DST_CNT_ADV, DST_CNT_FIX, DST_WR
  } arg_dest_t;

  typedef enum logic [2:0] {
    PO_HOLD, PO_LOAD, PO_INC, PO_DEC, PO_MARK, PO_RESTORE
  } ptr_op_t;

  // command characters
  localparam logic [7:0] CMD_LD4  = 8'h41; // 'A'
  localparam logic [7:0] CMD_LD3  = 8'h53; // 'S'
  localparam logic [7:0] CMD_LD1  = 8'h61; // 'a'
  localparam logic [7:0] CMD_PRD  = 8'h52; // 'R'
  localparam logic [7:0] CMD_INC  = 8'h2B; // '+'
  localparam logic [7:0] CMD_DEC  = 8'h2D; // '-'
  localparam logic [7:0] CMD_CADV = 8'h4E; // 'N'
  localparam logic [7:0] CMD_CFIX = 8'h46; // 'F'
  localparam logic [7:0] CMD_WR4  = 8'h4C; // 'L'
  localparam logic [7:0] CMD_WR3  = 8'h54; // 'T'
  localparam logic [7:0] CMD_WR2  = 8'h57; // 'W'
  localparam logic [7:0] CMD_WR1  = 8'h42; // 'B'
  localparam logic [7:0] CMD_RD4  = 8'h6C; // 'l'
  localparam logic [7:0] CMD_RD3  = 8'h74; // 't'
  localparam logic [7:0] CMD_RD2  = 8'h77; // 'w'
  localparam logic [7:0] CMD_RD1  = 8'h62; // 'b'

endpackage

// File: rtl/bre_shift_in.sv
module bre_shift_in #(
  parameter int NB = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            push,
  input  logic [7:0]      din,
  output logic [8*NB-1:0] word
);
  localparam int DW = 8 * NB;

  logic [DW-1:0] acc;

  // word already includes the byte being pushed this cycle
  assign word = {acc[DW-9:0], din};

  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '0;
    else if (push)  acc <= {acc[DW-9:0], din};
  end
endmodule

// File: rtl/bre_shift_out.sv
module bre_shift_out #(
  parameter int NB  = 4,
  parameter int NBW = $clog2(NB + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [8*NB-1:0] word,
  input  logic [NBW-1:0]  nbytes,
  input  logic            ready,
  output logic            valid,
  output logic [7:0]      data
);
  localparam int DW = 8 * NB;

  logic [DW-1:0]  sr;
  logic [NBW-1:0] left;

  assign valid = (left != '0);
  assign data  = sr[DW-1 -: 8];

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      left <= '0;
    end else if (load) begin
      // align the first byte to the top of the register
      sr   <= word << (8 * (NB - int'(nbytes)));
      left <= nbytes;
    end else if (valid && ready) begin
      sr   <= sr << 8;
      left <= left - NBW'(1);
    end
  end
endmodule

// File: rtl/bre_ptr.sv
module bre_ptr
  import bre_pkg::*;
#(
  parameter int PW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  ptr_op_t       op,
  input  logic [PW-1:0] ld_val,
  input  logic [PW-1:0] ld_mask,
  input  logic          cnt_ld,
  input  logic [CW-1:0] cnt_val,
  input  logic          cnt_fixed,
  output logic [PW-1:0] ptr,
  output logic [CW-1:0] cnt,
  output logic          fixed
);
  logic [PW-1:0] start;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr   <= '0;
      start <= '0;
      cnt   <= CW'(1);
      fixed <= 1'b0;
    end else begin
      case (op)
        PO_LOAD:    ptr   <= (ptr & ~ld_mask) | (ld_val & ld_mask);
        PO_INC:     ptr   <= ptr + PW'(1);
        PO_DEC:     ptr   <= ptr - PW'(1);
        PO_MARK:    start <= ptr;
        PO_RESTORE: begin
          ptr <= start;
          cnt <= CW'(1);
        end
        default: ;
      endcase
      if (cnt_ld) begin
        cnt   <= cnt_val;
        fixed <= cnt_fixed;
      end
    end
  end
endmodule

// File: rtl/byte_reg_engine.sv
module byte_reg_engine
  import bre_pkg::*;
#(
  parameter int BUS_AW = 24,
  parameter int CNT_W  = 16,
  parameter int MAX_NB = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic [7:0]                  in_data,
  output logic                        in_ready,
  output logic                        out_valid,
  output logic [7:0]                  out_data,
  input  logic                        out_ready,
  output logic [BUS_AW-1:0]           bus_addr,
  output logic [8*MAX_NB-1:0]         bus_wdata,
  output logic [$clog2(MAX_NB)-1:0]   bus_width,
  output logic                        bus_wr,
  output logic                        bus_rd,
  input  logic [8*MAX_NB-1:0]         bus_rdata,
  input  logic                        bus_hit
);
  localparam int DW     = 8 * MAX_NB;
  localparam int NBW    = $clog2(MAX_NB + 1);
  localparam int WBW    = $clog2(MAX_NB);
  localparam int CNT_NB = CNT_W / 8;

  function automatic logic [DW-1:0] nb_mask(input logic [NBW-1:0] n);
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < MAX_NB; i++)
      if (i < int'(n)) m[8*i +: 8] = 8'hFF;
    return m;
  endfunction

  function automatic logic [NBW-1:0] cmd_nb(input logic [7:0] c);
    case (c)
      CMD_WR4, CMD_RD4: return NBW'(4);
      CMD_WR3, CMD_RD3: return NBW'(3);
      CMD_WR2, CMD_RD2: return NBW'(2);
      default:          return NBW'(1);
    endcase
  endfunction

  eng_state_t     state, st_n;
  arg_dest_t      dest, dest_n;
  logic [NBW-1:0] argleft, argleft_n;
  logic [NBW-1:0] wid, wid_n;
  logic [CNT_W-1:0] rem, rem_n, blk_len;

  logic           in_fire, so_busy, so_load, si_clr, si_push;
  logic [DW-1:0]  so_word, si_word, ld_mask, ptr;
  logic [NBW-1:0] so_nb;
  ptr_op_t        p_op;
  logic           cnt_ld, cnt_fix, fixed;
  logic [CNT_W-1:0] cnt;

  logic              wr_n, rd_n;
  logic [DW-1:0]     wdata_n;
  logic [WBW-1:0]    width_n;
  logic [BUS_AW-1:0] addr_n;

  assign so_busy  = out_valid;
  assign in_ready = ((state == ST_IDLE) || (state == ST_ARG)) && !so_busy;
  assign in_fire  = in_valid && in_ready;
  assign blk_len  = (cnt == '0) ? CNT_W'(1) : cnt;

  bre_shift_in #(.NB(MAX_NB)) u_sin (
    .clk(clk), .rst(rst), .clr(si_clr), .push(si_push),
    .din(in_data), .word(si_word)
  );

  bre_shift_out #(.NB(MAX_NB), .NBW(NBW)) u_sout (
    .clk(clk), .rst(rst), .load(so_load), .word(so_word), .nbytes(so_nb),
    .ready(out_ready), .valid(out_valid), .data(out_data)
  );

  bre_ptr #(.PW(DW), .CW(CNT_W)) u_ptr (
    .clk(clk), .rst(rst), .op(p_op), .ld_val(si_word), .ld_mask(ld_mask),
    .cnt_ld(cnt_ld), .cnt_val(si_word[CNT_W-1:0]), .cnt_fixed(cnt_fix),
    .ptr(ptr), .cnt(cnt), .fixed(fixed)
  );

  always_comb begin
    st_n      = state;
    dest_n    = dest;
    argleft_n = argleft;
    wid_n     = wid;
    rem_n     = rem;
    si_clr    = 1'b0;
    si_push   = 1'b0;
    so_load   = 1'b0;
    so_word   = '0;
    so_nb     = '0;
    p_op      = PO_HOLD;
    ld_mask   = '0;
    cnt_ld    = 1'b0;
    cnt_fix   = 1'b0;
    wr_n      = 1'b0;
    rd_n      = 1'b0;
    wdata_n   = bus_wdata;
    width_n   = bus_width;
    addr_n    = bus_addr;
    case (state)
      ST_IDLE: if (in_fire) begin
        si_clr = 1'b1;
        case (in_data)
          CMD_LD4, CMD_LD3, CMD_LD1: begin
            dest_n    = DST_PTR;
            wid_n     = (in_data == CMD_LD4) ? NBW'(4) :
                        (in_data == CMD_LD3) ? NBW'(3) : NBW'(1);
            argleft_n = wid_n;
            st_n      = ST_ARG;
          end
          CMD_CADV, CMD_CFIX: begin
            dest_n    = (in_data == CMD_CFIX) ? DST_CNT_FIX : DST_CNT_ADV;
            argleft_n = NBW'(CNT_NB);
            st_n      = ST_ARG;
          end
          CMD_WR4, CMD_WR3, CMD_WR2, CMD_WR1: begin
            dest_n    = DST_WR;
            wid_n     = cmd_nb(in_data);
            argleft_n = cmd_nb(in_data);
            rem_n     = blk_len;
            p_op      = PO_MARK;
            st_n      = ST_ARG;
          end
          CMD_RD4, CMD_RD3, CMD_RD2, CMD_RD1: begin
            wid_n = cmd_nb(in_data);
            rem_n = blk_len;
            p_op  = PO_MARK;
            st_n  = ST_RD;
          end
          CMD_PRD: begin
            so_load = 1'b1;
            so_word = ptr;
            so_nb   = NBW'(MAX_NB);
          end
          CMD_INC: p_op = PO_INC;
          CMD_DEC: p_op = PO_DEC;
          default: ;
        endcase
      end
      ST_ARG: if (in_fire) begin
        si_push   = 1'b1;
        argleft_n = argleft - NBW'(1);
        if (argleft == NBW'(1)) begin
          si_clr = 1'b1;
          case (dest)
            DST_PTR: begin
              p_op    = PO_LOAD;
              ld_mask = nb_mask(wid);
              st_n    = ST_IDLE;
            end
            DST_CNT_ADV, DST_CNT_FIX: begin
              cnt_ld  = 1'b1;
              cnt_fix = (dest == DST_CNT_FIX);
              st_n    = ST_IDLE;
            end
            default: begin
              wr_n    = 1'b1;
              wdata_n = si_word & nb_mask(wid);
              width_n = WBW'(wid - NBW'(1));
              addr_n  = ptr[BUS_AW-1:0];
              if (rem == CNT_W'(1)) begin
                p_op = PO_RESTORE;
                st_n = ST_IDLE;
              end else begin
                rem_n     = rem - CNT_W'(1);
                argleft_n = wid;
                if (!fixed) p_op = PO_INC;
              end
            end
          endcase
        end
      end
      ST_RD: if (!so_busy) begin
        rd_n    = 1'b1;
        addr_n  = ptr[BUS_AW-1:0];
        width_n = WBW'(wid - NBW'(1));
        st_n    = ST_STRB;
      end
      ST_STRB: st_n = ST_CAP;
      ST_CAP: begin
        so_load = 1'b1;
        so_word = bus_hit ? (bus_rdata & nb_mask(wid)) : nb_mask(wid);
        so_nb   = wid;
        if (rem == CNT_W'(1)) begin
          p_op = PO_RESTORE;
          st_n = ST_IDLE;
        end else begin
          rem_n = rem - CNT_W'(1);
          if (!fixed) p_op = PO_INC;
          st_n = ST_RD;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      dest      <= DST_PTR;
      argleft   <= '0;
      wid       <= NBW'(1);
      rem       <= CNT_W'(1);
      bus_wr    <= 1'b0;
      bus_rd    <= 1'b0;
      bus_wdata <= '0;
      bus_width <= '0;
      bus_addr  <= '0;
    end else begin
      state     <= st_n;
      dest      <= dest_n;
      argleft   <= argleft_n;
      wid       <= wid_n;
      rem       <= rem_n;
      bus_wr    <= wr_n;
      bus_rd    <= rd_n;
      bus_wdata <= wdata_n;
      bus_width <= width_n;
      bus_addr  <= addr_n;
    end
  end
endmodule

// File: rtl/bre_checker.sv
module bre_checker #(
  parameter int BUS_AW = 24,
  parameter int MAX_NB = 4
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      in_ready,
  input logic                      out_valid,
  input logic [7:0]                out_data,
  input logic                      out_ready,
  input logic [8*MAX_NB-1:0]       bus_wdata,
  input logic [$clog2(MAX_NB)-1:0] bus_width,
  input logic                      bus_wr,
  input logic                      bus_rd
);
  AST_WR_RD_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_rd)); // R4

  AST_WDATA_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    bus_wr |-> ((bus_wdata >> (8 * (int'(bus_width) + 1))) == '0)); // R4

  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> !bus_rd); // R7

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7

  AST_RD_AFTER_DRAIN: assert property (@(posedge clk) disable iff (rst)
    bus_rd |-> !out_valid); // R9

  AST_IN_STALLED: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready); // R9

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_valid && !bus_wr && !bus_rd && in_ready)); // R10
endmodule

bind byte_reg_engine bre_checker #(.BUS_AW(BUS_AW), .MAX_NB(MAX_NB)) i_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
  .out_data(out_data), .out_ready(out_ready), .bus_wdata(bus_wdata),
  .bus_width(bus_width), .bus_wr(bus_wr), .bus_rd(bus_rd)
);

// File: tb/test_byte_reg_engine.sv
module test_byte_reg_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_ready = 1'b1;
  logic [23:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [1:0]  bus_width;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_rdata = '0;
  logic        bus_hit = 1'b0;

  always #5 clk = ~clk;

  byte_reg_engine i_byte_reg_engine (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_width(bus_width), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .bus_hit(bus_hit)
  );

  // bus model and logs: unit 0xEE is absent
  logic [23:0] wa [0:63];
  logic [31:0] wd [0:63];
  logic [1:0]  ww [0:63];
  logic [23:0] ra [0:63];
  logic [7:0]  rx [0:255];
  int wr_n = 0, rd_n = 0, rx_n = 0;

  always @(posedge clk) begin
    if (bus_rd) begin
      bus_rdata <= {bus_addr[7:0], ~bus_addr[7:0], bus_addr[15:8], bus_addr[7:0] + 8'd1};
      bus_hit   <= (bus_addr[15:8] != 8'hEE);
      ra[rd_n[5:0]] <= bus_addr;
      rd_n <= rd_n + 1;
    end
    if (bus_wr) begin
      wa[wr_n[5:0]] <= bus_addr;
      wd[wr_n[5:0]] <= bus_wdata;
      ww[wr_n[5:0]] <= bus_width;
      wr_n <= wr_n + 1;
    end
    if (out_valid && out_ready) begin
      rx[rx_n[7:0]] <= out_data;
      rx_n <= rx_n + 1;
    end
  end

  int  n_tests = 0, n_fail = 0;
  bit  done = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (!(in_ready && !out_valid)) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic read_ptr(output logic [31:0] v);
    int base;
    base = rx_n;
    put(8'h52);
    wait_idle();
    v = {rx[base[7:0]], rx[8'(base + 1)], rx[8'(base + 2)], rx[8'(base + 3)]};
  endtask

  function automatic logic [31:0] rx4(input int base);
    return {rx[base[7:0]], rx[8'(base + 1)], rx[8'(base + 2)], rx[8'(base + 3)]};
  endfunction

  // {count, six command bytes in order, expected pointer}
  localparam logic [87:0] PTAB [8] = '{
    {8'd5, 48'h41_12_34_56_78_00, 32'h12345678},
    {8'd4, 48'h53_AB_CD_EF_00_00, 32'h12ABCDEF},
    {8'd2, 48'h61_05_00_00_00_00, 32'h12ABCD05},
    {8'd1, 48'h2B_00_00_00_00_00, 32'h12ABCD06},
    {8'd2, 48'h2D_2D_00_00_00_00, 32'h12ABCD04},
    {8'd6, 48'h41_FF_FF_FF_FF_2B, 32'h00000000},
    {8'd1, 48'h2D_00_00_00_00_00, 32'hFFFFFFFF},
    {8'd3, 48'h71_61_10_00_00_00, 32'hFFFFFF10}
  };

  initial begin
    logic [31:0] v;
    int w0, r0, x0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    check("R10 in_ready", 32'(in_ready), 32'd1);
    check("R10 out_valid", 32'(out_valid), 32'd0);
    check("R10 strobes", {30'd0, bus_wr, bus_rd}, 32'd0);
    read_ptr(v);
    check("R10 pointer", v, 32'h0);
    w0 = wr_n;
    put(8'h42); put(8'h55); wait_idle();
    check("R10 count one", wr_n - w0, 1);
    check("R10 addr", 32'(wa[w0[5:0]]), 32'h0);

    // pointer table (R1 R2 R3)
    for (int i = 0; i < 8; i++) begin
      for (int k = 0; k < int'(PTAB[i][87:80]); k++) put(PTAB[i][79 - 8*k -: 8]);
      read_ptr(v);
      check($sformatf("R1 R2 R3 pointer row %0d", i), v, PTAB[i][31:0]);
    end

    // R3: unknown byte makes no bus cycle and no output
    w0 = wr_n; r0 = rd_n; x0 = rx_n;
    put(8'h7A); wait_idle();
    check("R3 no activity", (wr_n - w0) + (rd_n - r0) + (rx_n - x0), 0);

    // R4 single word write, upper pointer bits ignored
    put(8'h41); put(8'h7F); put(8'h01); put(8'h02); put(8'h10);
    w0 = wr_n;
    put(8'h57); put(8'hBE); put(8'hEF); wait_idle();
    check("R4 write count", wr_n - w0, 1);
    check("R4 addr", 32'(wa[w0[5:0]]), 32'h010210);
    check("R4 width", 32'(ww[w0[5:0]]), 32'd1);
    check("R4 data", wd[w0[5:0]], 32'h0000BEEF);

    // R5 advancing block of bytes, R6 restore
    put(8'h4E); put(8'h00); put(8'h03);
    w0 = wr_n;
    put(8'h42); put(8'h11); put(8'h22); put(8'h33); wait_idle();
    check("R5 block count", wr_n - w0, 3);
    for (int k = 0; k < 3; k++) begin
      check("R5 advancing addr", 32'(wa[6'(w0 + k)]), 32'h010210 + 32'(k));
      check("R4 byte data", wd[6'(w0 + k)], 32'h11 * 32'(k + 1));
    end
    read_ptr(v);
    check("R6 pointer restored", v, 32'h7F010210);
    w0 = wr_n;
    put(8'h4C); put(8'h01); put(8'h02); put(8'h03); put(8'h04); wait_idle();
    check("R6 count back to one", wr_n - w0, 1);
    check("R4 long data", wd[w0[5:0]], 32'h01020304);
    check("R4 long width", 32'(ww[w0[5:0]]), 32'd3);

    // R5 fixed block of triples
    put(8'h46); put(8'h00); put(8'h02);
    w0 = wr_n;
    put(8'h54); put(8'hAA); put(8'hBB); put(8'hCC); put(8'h11); put(8'h22); put(8'h33);
    wait_idle();
    check("R5 fixed count", wr_n - w0, 2);
    check("R5 fixed addr", {8'd0, wa[w0[5:0]]} ^ {8'd0, wa[6'(w0 + 1)]}, 32'h0);
    check("R4 triple data 0", wd[w0[5:0]], 32'h00AABBCC);
    check("R4 triple data 1", wd[6'(w0 + 1)], 32'h00112233);
    check("R4 triple width", 32'(ww[w0[5:0]]), 32'd2);

    // R7 advancing byte reads
    put(8'h61); put(8'h00);
    put(8'h4E); put(8'h00); put(8'h03);
    r0 = rd_n; x0 = rx_n;
    put(8'h62); wait_idle();
    check("R7 read count", rd_n - r0, 3);
    check("R7 bytes", {8'd0, rx[x0[7:0]], rx[8'(x0 + 1)], rx[8'(x0 + 2)]}, 32'h00010203);
    check("R7 last addr", 32'(ra[6'(r0 + 2)]), 32'h010202);
    read_ptr(v);
    check("R6 pointer after read block", v, 32'h7F010200);

    // R7 fixed word reads
    put(8'h46); put(8'h00); put(8'h02);
    r0 = rd_n; x0 = rx_n;
    put(8'h77); wait_idle();
    check("R7 fixed word bytes", rx4(x0), 32'h02010201);
    check("R5 fixed read addr", 32'(ra[6'(r0 + 1)]), 32'h010200);

    // R9 read strobe waits for stalled output
    out_ready = 1'b0;
    put(8'h4E); put(8'h00); put(8'h02);
    r0 = rd_n; x0 = rx_n;
    put(8'h6C);
    repeat (20) @(negedge clk);
    check("R9 one strobe while stalled", rd_n - r0, 1);
    check("R9 in_ready low", 32'(in_ready), 32'd0);
    check("R7 byte held", {23'd0, out_valid, out_data}, 32'h100);
    out_ready = 1'b1;
    wait_idle();
    check("R9 second strobe after drain", rd_n - r0, 2);
    check("R7 long item 0", rx4(x0), 32'h00FF0201);
    check("R7 long item 1", rx4(x0 + 4), 32'h01FE0202);

    // R8 absent unit
    put(8'h41); put(8'h00); put(8'h00); put(8'hEE); put(8'h00);
    x0 = rx_n;
    put(8'h62); put(8'h74); wait_idle();
    check("R8 byte miss", 32'(rx[x0[7:0]]), 32'hFF);
    check("R8 triple miss", {8'd0, rx[8'(x0 + 1)], rx[8'(x0 + 2)], rx[8'(x0 + 3)]}, 32'h00FFFFFF);

    // R5 count of zero moves one item
    put(8'h4E); put(8'h00); put(8'h00);
    w0 = wr_n;
    put(8'h42); put(8'h77); wait_idle();
    check("R5 zero count", wr_n - w0, 1);
    check("R4 addr of zero count", 32'(wa[w0[5:0]]), 32'h00EE00);
    check("R4 data of zero count", wd[w0[5:0]], 32'h77);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule